// File: doc/BRIEF.md
# Divider Issue and Completion Controller

This controller decides, cycle by cycle, whether a decoded floating-point instruction may enter the pipeline. The pipeline has a shared main arithmetic path and a separate long-running divide/square-root unit. A divide or square root uses the main path only for a few setup cycles at its start and a few finishing cycles at its end. Between those slots the main path is free, so short instructions issued after the divide keep flowing and can finish before it. The divide result is written back out of order.

The controller counts down the divider's occupancy and reserves the main path for the divider's start and end slots. It records the destination register of the pending divide. It holds any instruction that would break ordering: a second divide, an instruction that touches the pending destination, or a second early-stage instruction directly behind another one. The front end presents one instruction with `in_valid` and keeps it steady until `issue_o` is seen.

Top module: `fpic_issue_ctrl`

## Requirements
- R1: `issue_o` is 1 exactly when `in_valid` is 1 and `stall_o` is 0. With `in_valid` at 0, neither `issue_o` nor `stall_o` is asserted. Class encoding on `in_cls`: 0 plain arithmetic, 1 early-stage arithmetic, 2 divide, 3 square root.
- R2: An issued divide occupies the divider for 10 cycles in single precision and 23 in double precision, counting the issue cycle as the first. `div_busy_o` is 1 from the cycle after issue through the last occupancy cycle. `div_wb_o` pulses for one cycle in the last occupancy cycle.
- R3: A square root occupies the divider for one cycle fewer than a divide of the same precision: 9 cycles in single precision and 22 in double.
- R4: In single precision, the divider's start slot is its issue cycle. Its only reserved cycle afterwards is the last occupancy cycle, where `main_rsv_o` is 1.
- R5: In double precision, `main_rsv_o` is 1 in the cycle after issue and in the last three occupancy cycles.
- R6: In every other occupancy cycle, an arithmetic instruction with no register conflict issues. Short instructions therefore complete ahead of the divide.
- R7: A divide or square root presented while `div_busy_o` is 1 is stalled. One presented in the cycle after the writeback cycle issues.
- R8: While `div_busy_o` is 1, an arithmetic instruction is stalled if either of its sources or its destination equals the pending divide destination. After writeback it issues.
- R9: An early-stage instruction (class 1) is stalled for one cycle when an early-stage instruction issued in the previous cycle.
- R10: A reserved main-path slot stalls any instruction presented in that cycle.
- R11: During the writeback pulse, `div_wb_dst_o` equals the destination register of the divide being completed.
- R12: While reset is asserted, and after it is released, the controller is idle: not busy, no reservation, no writeback, and an arithmetic instruction issues.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | An instruction is presented |
| in_cls | input | 2 | Instruction class (0 arith, 1 early arith, 2 divide, 3 sqrt) |
| in_dp | input | 1 | Double precision when 1 |
| in_src_a | input | REG_W | First source register |
| in_src_b | input | REG_W | Second source register |
| in_dst | input | REG_W | Destination register |
| issue_o | output | 1 | Presented instruction is accepted this cycle |
| stall_o | output | 1 | Presented instruction is held this cycle |
| div_busy_o | output | 1 | Divider occupied after its issue cycle |
| main_rsv_o | output | 1 | Main path taken by divider setup or finishing slot |
| div_wb_o | output | 1 | Divider result written back this cycle |
| div_wb_dst_o | output | REG_W | Destination register of the pending divide |

## Verification
The hardest case to reach is a reserved finishing slot in the same cycle as a ready instruction that has no hazard of its own. It happens in only one to three cycles out of more than twenty, and its position depends on precision and operation. The stimulus issues each divide variant and then presents an independent arithmetic instruction in every following cycle. It checks issue, reservation, busy and writeback against a schedule computed from the occupancy lengths. The cycle after writeback is used to issue a fresh divide, which also tests the restart boundary.

// File: rtl/fpic_pkg.sv
package fpic_pkg;
  typedef enum logic [1:0] {
    CLS_ARITH = 2'd0,
    CLS_EARLY = 2'd1,
    CLS_DIV   = 2'd2,
    CLS_SQRT  = 2'd3
  } op_cls_e;
endpackage

// File: rtl/fpic_div_track.sv
module fpic_div_track #(
  parameter int REG_W    = 4,
  parameter int SP_CYC   = 10,
  parameter int DP_CYC   = 23,
  parameter int SP_START = 1,
  parameter int SP_END   = 1,
  parameter int DP_START = 2,
  parameter int DP_END   = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             dp_i,
  input  logic             sqrt_i,
  input  logic [REG_W-1:0] dst_i,
  output logic             busy_o,
  output logic             rsv_o,
  output logic             wb_o,
  output logic [REG_W-1:0] dst_o
);
  localparam int CNT_W = $clog2(DP_CYC + 1);
  localparam logic [CNT_W-1:0] SP_LEN  = CNT_W'(SP_CYC);
  localparam logic [CNT_W-1:0] DP_LEN  = CNT_W'(DP_CYC);
  localparam logic [CNT_W-1:0] SP_HEAD = CNT_W'(SP_START);
  localparam logic [CNT_W-1:0] DP_HEAD = CNT_W'(DP_START);
  localparam logic [CNT_W-1:0] SP_TAIL = CNT_W'(SP_END);
  localparam logic [CNT_W-1:0] DP_TAIL = CNT_W'(DP_END);
  localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d, len_q, len_d, len_sel;
  logic [CNT_W-1:0] head_len, tail_len;
  logic             dp_q, dp_d;
  logic [REG_W-1:0] dst_q, dst_d;
  logic             cnt_en, load_en;

  // next-state
  always_comb begin
    len_sel = dp_i ? DP_LEN : SP_LEN;
    if (sqrt_i) len_sel = len_sel - ONE;
    busy_o  = (cnt_q != '0);
    cnt_en  = start_i | busy_o;
    load_en = start_i;
    cnt_d   = start_i ? (len_sel - ONE) : (cnt_q - ONE);
    len_d   = len_sel;
    dp_d    = dp_i;
    dst_d   = dst_i;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      len_q <= '0;
      dp_q  <= 1'b0;
      dst_q <= '0;
    end else begin
      if (cnt_en)  cnt_q <= cnt_d;
      if (load_en) begin
        len_q <= len_d;
        dp_q  <= dp_d;
        dst_q <= dst_d;
      end
    end
  end

  // slot decode: counter equals len - k + 1 in occupancy cycle k
  always_comb begin
    head_len = dp_q ? DP_HEAD : SP_HEAD;
    tail_len = dp_q ? DP_TAIL : SP_TAIL;
    rsv_o    = busy_o & ((cnt_q > (len_q - head_len)) | (cnt_q <= tail_len));
    wb_o     = (cnt_q == ONE);
    dst_o    = dst_q;
  end

  // R2
  wb_then_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_o && !start_i |=> !busy_o);
  // R7
  no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |-> !busy_o);
  // R2
  busy_from_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(start_i));
endmodule

// File: rtl/fpic_hazard.sv
module fpic_hazard
  import fpic_pkg::*;
#(
  parameter int REG_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  op_cls_e          cls_i,
  input  logic [REG_W-1:0] src_a_i,
  input  logic [REG_W-1:0] src_b_i,
  input  logic [REG_W-1:0] dst_i,
  input  logic             pend_busy_i,
  input  logic [REG_W-1:0] pend_dst_i,
  input  logic             issued_i,
  output logic             dep_stall_o,
  output logic             early_stall_o
);
  logic prev_early_q, prev_early_d;
  logic is_short, is_early, hit;

  always_comb begin
    is_short      = (cls_i == CLS_ARITH) || (cls_i == CLS_EARLY);
    is_early      = (cls_i == CLS_EARLY);
    hit           = (src_a_i == pend_dst_i) || (src_b_i == pend_dst_i) ||
                    (dst_i == pend_dst_i);
    dep_stall_o   = pend_busy_i & is_short & hit;
    early_stall_o = is_early & prev_early_q;
    prev_early_d  = issued_i & is_early;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_early_q <= 1'b0;
    else        prev_early_q <= prev_early_d;
  end

  // R9
  early_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issued_i && is_early |=> !(issued_i && is_early));
  // R8
  dep_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issued_i && pend_busy_i && is_short |->
      (src_a_i != pend_dst_i) && (src_b_i != pend_dst_i) && (dst_i != pend_dst_i));
endmodule

// File: rtl/fpic_issue_ctrl.sv
module fpic_issue_ctrl
  import fpic_pkg::*;
#(
  parameter int REG_W    = 4,
  parameter int SP_CYC   = 10,
  parameter int DP_CYC   = 23,
  parameter int SP_START = 1,
  parameter int SP_END   = 1,
  parameter int DP_START = 2,
  parameter int DP_END   = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [1:0]       in_cls,
  input  logic             in_dp,
  input  logic [REG_W-1:0] in_src_a,
  input  logic [REG_W-1:0] in_src_b,
  input  logic [REG_W-1:0] in_dst,
  output logic             issue_o,
  output logic             stall_o,
  output logic             div_busy_o,
  output logic             main_rsv_o,
  output logic             div_wb_o,
  output logic [REG_W-1:0] div_wb_dst_o
);
  logic    rst_s1_q, rst_s2_q, rst_int_n;
  op_cls_e cls;
  logic    is_long, is_sqrt, div_start;
  logic    dep_stall, early_stall, busy_stall;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_s2_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s2_q <= rst_s1_q;
    end
  end
  assign rst_int_n = rst_s2_q & rst_n;

  always_comb begin
    cls        = op_cls_e'(in_cls);
    is_long    = (cls == CLS_DIV) || (cls == CLS_SQRT);
    is_sqrt    = (cls == CLS_SQRT);
    busy_stall = is_long & div_busy_o;
    stall_o    = in_valid & (main_rsv_o | busy_stall | dep_stall | early_stall);
    issue_o    = in_valid & ~stall_o;
    div_start  = issue_o & is_long;
  end

  fpic_div_track #(
    .REG_W(REG_W), .SP_CYC(SP_CYC), .DP_CYC(DP_CYC),
    .SP_START(SP_START), .SP_END(SP_END), .DP_START(DP_START), .DP_END(DP_END)
  ) u_track (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .start_i (div_start),
    .dp_i    (in_dp),
    .sqrt_i  (is_sqrt),
    .dst_i   (in_dst),
    .busy_o  (div_busy_o),
    .rsv_o   (main_rsv_o),
    .wb_o    (div_wb_o),
    .dst_o   (div_wb_dst_o)
  );

  fpic_hazard #(.REG_W(REG_W)) u_haz (
    .clk           (clk),
    .rst_n         (rst_int_n),
    .cls_i         (cls),
    .src_a_i       (in_src_a),
    .src_b_i       (in_src_b),
    .dst_i         (in_dst),
    .pend_busy_i   (div_busy_o),
    .pend_dst_i    (div_wb_dst_o),
    .issued_i      (issue_o),
    .dep_stall_o   (dep_stall),
    .early_stall_o (early_stall)
  );

  // R10
  rsv_blocks_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    main_rsv_o |-> !issue_o);
  // R4
  wb_slot_rsv_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    div_wb_o |-> main_rsv_o);
  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    !in_valid |-> !issue_o && !stall_o);
endmodule

// File: tb/fpic_issue_ctrl_test.sv
module fpic_issue_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       in_valid, in_dp;
  logic [1:0] in_cls;
  logic [3:0] in_src_a, in_src_b, in_dst;
  logic       issue_o, stall_o, div_busy_o, main_rsv_o, div_wb_o;
  logic [3:0] div_wb_dst_o;
  int         n_run = 0;
  int         n_fail = 0;

  always #10 clk = ~clk;

  fpic_issue_ctrl uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_cls(in_cls), .in_dp(in_dp),
    .in_src_a(in_src_a), .in_src_b(in_src_b), .in_dst(in_dst),
    .issue_o(issue_o), .stall_o(stall_o), .div_busy_o(div_busy_o),
    .main_rsv_o(main_rsv_o), .div_wb_o(div_wb_o), .div_wb_dst_o(div_wb_dst_o)
  );

  // {valid, cls[1:0], dp, a[3:0], b[3:0], d[3:0], issue, rsv, busy, wb}
  localparam logic [19:0] VEC [0:13] = '{
    {1'b0, 2'd0, 1'b0, 4'd0, 4'd0, 4'd0, 4'b0000}, // idle
    {1'b1, 2'd2, 1'b0, 4'd0, 4'd0, 4'd5, 4'b1000}, // SP divide -> r5
    {1'b1, 2'd0, 1'b0, 4'd1, 4'd2, 4'd3, 4'b1010}, // R6 independent
    {1'b1, 2'd0, 1'b0, 4'd5, 4'd2, 4'd3, 4'b0010}, // R8 reads r5
    {1'b1, 2'd0, 1'b0, 4'd1, 4'd2, 4'd5, 4'b0010}, // R8 writes r5
    {1'b1, 2'd1, 1'b0, 4'd1, 4'd2, 4'd6, 4'b1010}, // early issues
    {1'b1, 2'd1, 1'b0, 4'd2, 4'd3, 4'd7, 4'b0010}, // R9 held
    {1'b1, 2'd1, 1'b0, 4'd2, 4'd3, 4'd7, 4'b1010}, // R9 released
    {1'b1, 2'd3, 1'b0, 4'd1, 4'd2, 4'd9, 4'b0010}, // R7 sqrt while busy
    {1'b1, 2'd0, 1'b0, 4'd1, 4'd2, 4'd3, 4'b1010}, // R6
    {1'b1, 2'd0, 1'b0, 4'd1, 4'd2, 4'd3, 4'b0111}, // R4 R10 finishing slot
    {1'b1, 2'd0, 1'b0, 4'd5, 4'd2, 4'd3, 4'b1000}, // R8 cleared
    {1'b1, 2'd1, 1'b0, 4'd1, 4'd2, 4'd3, 4'b1000}, // early after plain
    {1'b0, 2'd0, 1'b0, 4'd0, 4'd0, 4'd0, 4'b0000}  // R1 idle
  };

  task automatic chk(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic drive(input logic v, input logic [1:0] c, input logic dp,
                       input logic [3:0] a, input logic [3:0] b, input logic [3:0] d);
    @(negedge clk);
    in_valid = v; in_cls = c; in_dp = dp; in_src_a = a; in_src_b = b; in_dst = d;
    #5;
  endtask

  // issue a long op, then offer independent work every cycle
  task automatic run_div(input string tag, input logic [1:0] c, input logic dp,
                         input int len, input int head, input int tail, input logic [3:0] d);
    drive(1'b1, c, dp, 4'd1, 4'd2, d);
    chk({tag, " issue"}, issue_o, 1);
    for (int k = 2; k <= len + 1; k++) begin
      bit rsv_exp;
      rsv_exp = (k <= len) && ((k <= head) || (k > len - tail));
      if (k == len + 1) begin
        drive(1'b1, 2'd2, 1'b0, 4'd1, 4'd2, 4'd11);
        chk("R7 restart after wb", issue_o, 1);
      end else begin
        drive(1'b1, 2'd0, 1'b0, 4'd1, 4'd2, 4'd12);
        chk({tag, " R6 issue"}, issue_o, rsv_exp ? 0 : 1);
        chk({tag, " rsv"}, main_rsv_o, rsv_exp);
        chk({tag, " busy"}, div_busy_o, 1);
        chk({tag, " wb"}, div_wb_o, k == len);
        if (k == len) chk("R11 wb dst", div_wb_dst_o, d);
      end
    end
    for (int i = 0; i < 12; i++) drive(1'b0, 2'd0, 1'b0, 4'd0, 4'd0, 4'd0);
    chk({tag, " drained"}, div_busy_o, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got 1 expected 0");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    in_valid = 0; in_cls = 0; in_dp = 0; in_src_a = 0; in_src_b = 0; in_dst = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R12 reset state
    drive(1'b1, 2'd0, 1'b0, 4'd1, 4'd2, 4'd3);
    chk("R12 issue", issue_o, 1);
    chk("R12 busy", div_busy_o, 0);
    chk("R12 rsv", main_rsv_o, 0);
    chk("R12 wb", div_wb_o, 0);
    drive(1'b0, 2'd0, 1'b0, 4'd0, 4'd0, 4'd0);
    chk("R1 idle issue", issue_o, 0);
    chk("R1 idle stall", stall_o, 0);

    foreach (VEC[i]) begin
      logic [19:0] v;
      v = VEC[i];
      drive(v[19], v[18:17], v[16], v[15:12], v[11:8], v[7:4]);
      chk($sformatf("R1 vec%0d issue", i), issue_o, v[3]);
      chk($sformatf("R1 vec%0d stall", i), stall_o, v[19] & ~v[3]);
      chk($sformatf("R4 vec%0d rsv", i), main_rsv_o, v[2]);
      chk($sformatf("R2 vec%0d busy", i), div_busy_o, v[1]);
      chk($sformatf("R2 vec%0d wb", i), div_wb_o, v[0]);
    end

    run_div("R2 R4 sp div", 2'd2, 1'b0, 10, 1, 1, 4'd9);
    run_div("R3 R4 sp sqrt", 2'd3, 1'b0, 9, 1, 1, 4'd8);
    run_div("R2 R5 dp div", 2'd2, 1'b1, 23, 2, 3, 4'd7);
    run_div("R3 R5 dp sqrt", 2'd3, 1'b1, 22, 2, 3, 4'd6);

    // R12 reset during an operation
    drive(1'b1, 2'd2, 1'b1, 4'd1, 4'd2, 4'd4);
    repeat (3) drive(1'b0, 2'd0, 1'b0, 4'd0, 4'd0, 4'd0);
    chk("R12 busy before reset", div_busy_o, 1);
    rst_n = 1'b0;
    #1;
    chk("R12 busy in reset", div_busy_o, 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) drive(1'b0, 2'd0, 1'b0, 4'd0, 4'd0, 4'd0);
    drive(1'b1, 2'd0, 1'b0, 4'd4, 4'd2, 4'd3);
    chk("R12 R8 no stale dst", issue_o, 1);
    chk("R12 no rsv", main_rsv_o, 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule